// File: doc/BRIEF.md
# Bus Cycle Wait-State Controller

This block runs the external bus cycles of a bus master. A transfer request starts a cycle. The cycle then moves through a start phase and a wait phase and ends with a closing phase. The wait phase lasts as long as the slower of two limits. The first is a minimum wait-state count taken from a control-register field. The second is an open-ended extension held by a synchronous, active-low transfer-acknowledge input.

The current phase is exported as a two-bit status code. An address strobe and a data strobe are decoded from that code, so external logic can latch the address and the data. The acknowledge input is captured on the falling clock edge. It counts only while the block owns the bus and a wait phase is in progress.

When a request is present during the closing phase, the next cycle starts on the following clock, with no idle gap. Otherwise the block returns to idle.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to idle: `bus_phase` = 2'b11, and both strobes are high (inactive) on the following clock.
- R2: `bus_phase` carries one of four codes: 2'b11 idle, 2'b10 cycle start, 2'b00 wait, 2'b01 cycle end. Each cycle runs in the order start, wait, end.
- R3: From idle, the block enters cycle start on the clock after `xfer_req` and `bus_owner` are both seen high. Cycle start lasts exactly one clock and is always followed by wait.
- R4: With minimum count N (`min_wait`, loaded at cycle start), and with acknowledge first driven low in wait clock D (counting from 0), the wait phase lasts max(N, D) + 1 clocks.
- R5: `xfer_ack_n` is sampled on the falling clock edge. The cycle-end phase begins at the rising edge that follows a low sample, provided the wait count has run out.
- R6: While acknowledge stays high, the wait phase continues with no upper limit (checked past 500 clocks).
- R7: Acknowledge has no effect while the block is idle, or while `bus_owner` is low. A wait phase does not end while `bus_owner` is low, and idle is not left while `bus_owner` is low.
- R8: `addr_stb_n` is low whenever `bus_phase` is not 2'b11. `data_stb_n` is low exactly when `bus_phase` is 2'b00 or 2'b01.
- R9: From cycle end, the block enters cycle start on the next clock when `xfer_req` and `bus_owner` are high. Otherwise it returns to idle.
- R10: With acknowledge held low and `min_wait` = 0, a cycle takes three clocks (start, one wait clock, end), and back-to-back cycles repeat with a period of three clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; phases advance on the rising edge, acknowledge is captured on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_owner | input | 1 | High while this block owns the external bus |
| xfer_req | input | 1 | Request to start a bus cycle |
| min_wait | input | WAIT_W | Minimum wait-state count from the control register |
| xfer_ack_n | input | 1 | Active-low transfer acknowledge |
| bus_phase | output | 2 | Phase code: 11 idle, 10 start, 00 wait, 01 end |
| addr_stb_n | output | 1 | Active-low address strobe |
| data_stb_n | output | 1 | Active-low data strobe |

## Verification
Two events can meet in the same wait clock: the minimum counter reaches zero, and the acknowledge arrives low. The bench sweeps every pair of minimum count and acknowledge delay over a small grid, which includes every case where the two coincide. For each pair it compares the measured wait length with max(N, D) + 1. A second same-cycle meeting is a new request that lands on the closing phase. The bench holds the request high through back-to-back cycles and expects the start code immediately after each end code, with no idle clock between them.

// File: rtl/bwc_pkg.sv
// Package: shared phase encoding for the bus wait-state controller.
// Assumes two status lines; the code values are part of the external contract.
package bwc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b11,
        PH_START = 2'b10,
        PH_WAIT  = 2'b00,
        PH_END   = 2'b01
    } phase_t;

endpackage

// File: rtl/bwc_ack_sampler.sv
// Module: bwc_ack_sampler
// Captures the active-low acknowledge on the falling clock edge and presents it
// as an active-high "seen" flag for the next rising edge.
// Assumes the acknowledge is synchronous to clk. Reset is synchronous and
// active low, and is applied on the falling edge as well.
module bwc_ack_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic ack_seen
);

    // Falling-edge capture of the acknowledge level.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ~ack_n;
        end
    end

endmodule

// File: rtl/bwc_wait_counter.sv
// Module: bwc_wait_counter
// Holds the remaining minimum wait states of the current cycle. It loads the
// register value when a cycle starts and counts down to zero, where it stays.
// Assumes load and count are never asserted together by the controller; load wins.
module bwc_wait_counter #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              count_en,
    output logic              at_zero
);

    localparam logic [WAIT_W-1:0] ZERO = '0;
    localparam logic [WAIT_W-1:0] ONE  = {{(WAIT_W-1){1'b0}}, 1'b1};

    logic [WAIT_W-1:0] remain;

    // Load at cycle start, otherwise saturating decrement while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= ZERO;
        end else if (load) begin
            remain <= load_val;
        end else if (count_en && (remain != ZERO)) begin
            remain <= remain - ONE;
        end
    end

    // Zero flag used by the phase machine to permit cycle end.
    always_comb begin
        at_zero = (remain == ZERO);
    end

endmodule

// File: rtl/bwc_phase_fsm.sv
// Module: bwc_phase_fsm
// Four-phase bus cycle sequencer: idle, start, wait, end. A cycle leaves wait
// only when the minimum counter is exhausted and an acknowledge was sampled
// while owning the bus. A request in the end phase chains a new cycle.
// Assumes ack_seen comes from the falling-edge sampler.
module bwc_phase_fsm
    import bwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_owner,
    input  logic   xfer_req,
    input  logic   ack_seen,
    input  logic   cnt_zero,
    output phase_t phase,
    output logic   cnt_load,
    output logic   cnt_count
);

    phase_t phase_nxt;
    logic   start_ok;
    logic   finish_ok;

    // Qualify the request and the acknowledge with bus ownership.
    always_comb begin
        start_ok  = xfer_req && bus_owner;
        finish_ok = ack_seen && bus_owner && cnt_zero;
    end

    // Next-phase selection.
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE:  if (start_ok) phase_nxt = PH_START;
            PH_START: phase_nxt = PH_WAIT;
            PH_WAIT:  if (finish_ok) phase_nxt = PH_END;
            PH_END:   phase_nxt = start_ok ? PH_START : PH_IDLE;
            default:  phase_nxt = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Counter control: load on entry to start, count through wait.
    always_comb begin
        cnt_load  = (phase_nxt == PH_START) && (phase != PH_START);
        cnt_count = (phase == PH_WAIT);
    end

endmodule

// File: rtl/bwc_strobe_decode.sv
// Module: bwc_strobe_decode
// Decodes the phase code into active-low address and data strobes.
// Assumes the phase code is glitch-free because it is registered.
module bwc_strobe_decode
    import bwc_pkg::*;
(
    input  phase_t      phase,
    output logic [1:0]  status,
    output logic        addr_stb_n,
    output logic        data_stb_n
);

    // Address strobe covers start through end; data strobe covers wait and end.
    always_comb begin
        status     = phase;
        addr_stb_n = (phase == PH_IDLE);
        data_stb_n = (phase == PH_IDLE) || (phase == PH_START);
    end

endmodule

// File: rtl/bus_wait_ctrl.sv
// Module: bus_wait_ctrl (top)
// Sequences external bus cycles. The wait phase length is the larger of a
// programmed minimum and an acknowledge-driven extension. It exports a two-bit
// phase code and the strobes decoded from it.
// Assumes all inputs are synchronous to clk; min_wait is read only at cycle start.
module bus_wait_ctrl #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_owner,
    input  logic              xfer_req,
    input  logic [WAIT_W-1:0] min_wait,
    input  logic              xfer_ack_n,
    output logic [1:0]        bus_phase,
    output logic              addr_stb_n,
    output logic              data_stb_n
);

    import bwc_pkg::*;

    logic   ack_seen;
    logic   cnt_zero;
    logic   cnt_load;
    logic   cnt_count;
    phase_t phase;

    bwc_ack_sampler u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (xfer_ack_n),
        .ack_seen (ack_seen)
    );

    bwc_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (min_wait),
        .count_en (cnt_count),
        .at_zero  (cnt_zero)
    );

    bwc_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_owner (bus_owner),
        .xfer_req  (xfer_req),
        .ack_seen  (ack_seen),
        .cnt_zero  (cnt_zero),
        .phase     (phase),
        .cnt_load  (cnt_load),
        .cnt_count (cnt_count)
    );

    bwc_strobe_decode u_stb (
        .phase      (phase),
        .status     (bus_phase),
        .addr_stb_n (addr_stb_n),
        .data_stb_n (data_stb_n)
    );

endmodule

// File: rtl/bwc_checker.sv
// Module: bwc_checker
// Property checks on the phase sequence and the strobes of bus_wait_ctrl,
// attached through bind. Observes ports plus the sampled acknowledge flag.
module bwc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_owner,
    input logic       xfer_req,
    input logic       ack_seen,
    input logic [1:0] bus_phase,
    input logic       addr_stb_n,
    input logic       data_stb_n
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_phase == 2'b11));

    assert_start_then_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'b10) |=> (bus_phase == 2'b00));

    assert_idle_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_phase == 2'b11) && !(xfer_req && bus_owner)) |=> (bus_phase == 2'b11));

    assert_end_only_from_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase != 2'b00) |=> (bus_phase != 2'b01));

    assert_wait_holds_without_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_phase == 2'b00) && !(ack_seen && bus_owner)) |=> (bus_phase == 2'b00));

    assert_end_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 2'b01) |=> ((bus_phase == 2'b10) || (bus_phase == 2'b11)));

    assert_data_inside_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_stb_n |-> !addr_stb_n);

endmodule

bind bus_wait_ctrl bwc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_owner  (bus_owner),
    .xfer_req   (xfer_req),
    .ack_seen   (ack_seen),
    .bus_phase  (bus_phase),
    .addr_stb_n (addr_stb_n),
    .data_stb_n (data_stb_n)
);

// File: tb/tb_bus_wait_ctrl.sv
module tb_bus_wait_ctrl;

    localparam int WAIT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_owner = 1'b0;
    logic              xfer_req = 1'b0;
    logic [WAIT_W-1:0] min_wait = '0;
    logic              xfer_ack_n = 1'b1;
    logic [1:0]        bus_phase;
    logic              addr_stb_n;
    logic              data_stb_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    bus_wait_ctrl #(.WAIT_W(WAIT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_owner  (bus_owner),
        .xfer_req   (xfer_req),
        .min_wait   (min_wait),
        .xfer_ack_n (xfer_ack_n),
        .bus_phase  (bus_phase),
        .addr_stb_n (addr_stb_n),
        .data_stb_n (data_stb_n)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Strobes expected from the phase code.
    task automatic check_strobes(input string tag);
        check(addr_stb_n == (bus_phase == 2'b11), tag, int'(addr_stb_n), int'(bus_phase == 2'b11));
        check(data_stb_n == bus_phase[1], tag, int'(data_stb_n), int'(bus_phase[1]));
    endtask

    // One cycle with minimum n and acknowledge first low in wait clock d.
    task automatic run_cycle(input int n, input int d);
        int w;
        min_wait   = WAIT_W'(n);
        xfer_ack_n = 1'b1;
        bus_owner  = 1'b1;
        xfer_req   = 1'b1;
        tick();
        check(bus_phase == 2'b10, "R3 start", int'(bus_phase), 2);
        check_strobes("R8 start");
        xfer_req = 1'b0;
        tick();
        check(bus_phase == 2'b00, "R2 wait after start", int'(bus_phase), 0);
        w = 0;
        while (bus_phase == 2'b00 && w < 64) begin
            if (w >= d) xfer_ack_n = 1'b0;
            w++;
            tick();
        end
        check(w == ((n > d) ? n : d) + 1, "R4 wait length (R5 end after ack)", w, ((n > d) ? n : d) + 1);
        check(bus_phase == 2'b01, "R2 end code", int'(bus_phase), 1);
        check_strobes("R8 end");
        xfer_ack_n = 1'b1;
        tick();
        check(bus_phase == 2'b11, "R9 end to idle", int'(bus_phase), 3);
        check_strobes("R8 idle");
    endtask

    initial begin
        // R1: reset
        repeat (3) tick();
        check(bus_phase == 2'b11, "R1 reset phase", int'(bus_phase), 3);
        check(addr_stb_n && data_stb_n, "R1 reset strobes", int'({addr_stb_n, data_stb_n}), 3);
        rst_n = 1'b1;
        tick();

        // R7: acknowledge in idle, and request without ownership
        xfer_ack_n = 1'b0;
        repeat (4) tick();
        check(bus_phase == 2'b11, "R7 ack ignored in idle", int'(bus_phase), 3);
        xfer_req = 1'b1;
        bus_owner = 1'b0;
        repeat (4) tick();
        check(bus_phase == 2'b11, "R7 no start without ownership", int'(bus_phase), 3);
        xfer_req = 1'b0;
        xfer_ack_n = 1'b1;
        tick();

        // R4/R5: sweep minimum against acknowledge delay (includes coincidences)
        for (int n = 0; n <= 5; n++) begin
            for (int d = 0; d <= 6; d++) begin
                run_cycle(n, d);
            end
        end

        // R10/R9: ack tied low, min 0, back-to-back cycles of period 3
        min_wait = '0;
        xfer_ack_n = 1'b0;
        bus_owner = 1'b1;
        xfer_req = 1'b1;
        for (int k = 0; k < 12; k++) begin
            tick();
            check(bus_phase == ((k % 3 == 0) ? 2'b10 : (k % 3 == 1) ? 2'b00 : 2'b01),
                  "R10 zero-wait chain (R9 restart)", int'(bus_phase),
                  (k % 3 == 0) ? 2 : (k % 3 == 1) ? 0 : 1);
        end
        xfer_req = 1'b0;
        tick();
        check(bus_phase == 2'b11, "R9 idle when no request", int'(bus_phase), 3);

        // R7: ownership lost during wait freezes the cycle despite ack
        xfer_ack_n = 1'b1;
        xfer_req = 1'b1;
        tick();
        xfer_req = 1'b0;
        tick();
        bus_owner = 1'b0;
        xfer_ack_n = 1'b0;
        repeat (5) tick();
        check(bus_phase == 2'b00, "R7 wait held without ownership", int'(bus_phase), 0);
        bus_owner = 1'b1;
        tick();
        check(bus_phase == 2'b01, "R7 end after ownership back", int'(bus_phase), 1);
        xfer_ack_n = 1'b1;
        tick();

        // R6: unbounded wait while acknowledge stays high
        min_wait = '0;
        xfer_req = 1'b1;
        tick();
        xfer_req = 1'b0;
        begin
            int held;
            held = 0;
            for (int k = 0; k < 600; k++) begin
                tick();
                if (bus_phase == 2'b00) held++;
            end
            check(held == 600, "R6 wait not limited", held, 600);
        end
        xfer_ack_n = 1'b0;
        tick();
        check(bus_phase == 2'b01, "R5 end one clock after ack", int'(bus_phase), 1);
        xfer_ack_n = 1'b1;
        tick();

        // R1: reset in mid-cycle
        xfer_req = 1'b1;
        tick();
        xfer_req = 1'b0;
        rst_n = 1'b0;
        tick();
        check(bus_phase == 2'b11, "R1 reset mid-cycle", int'(bus_phase), 3);
        check(addr_stb_n && data_stb_n, "R1 strobes after reset", int'({addr_stb_n, data_stb_n}), 3);
        rst_n = 1'b1;
        tick();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule